// File: doc/BRIEF.md
# Dual-Lane Link Supervisor with Clock-Recovery Retry

This block watches a set of serial receive lanes (two by default) and decides, once per periodic tick, whether each lane holds a usable link. The tick normally comes from a 100 ms timebase. On every tick each lane is handled in turn. The block reads the lane's loss-of-signal bit and its 32-bit receive status word, which carries a block-lock flag and an 8-bit block-error count. From these it moves a three-state link machine, drives a per-lane 2-bit signal-detect override, and issues write strobes that clear the lane's error counter.

When a lane lacks lock, the block reads the clock-recovery loop-filter value over a request/acknowledge test-bus port. If that value is off-centre, the block briefly forces the override to its reset code to restart clock recovery. An aggregate link-up output reports when all lanes are linked. A supervisor raises a timeout flag if link-up has not been reached within a fixed number of ticks after reset.

Lane state codes are SYNC = 0, LINKED = 1 and CHECK = 2. Lane `n` uses bits `[2n+1:2n]` of `lane_state` and `sd_ovr` and bits `[32n+31:32n]` of `lane_stat`.

Top module: `lane_link_mon`

## Requirements
- R1: After reset every lane is in SYNC (0), every override field is 0, `lane_down`, `link_up`, `timeout` and `busy` are 0.
- R2: A lane counts as locked only when status bit 30 is 1 and the error count in status bits 23:16 is not 0xFF; a count of 0xFF means not locked.
- R3: In SYNC, a lane with no loss of signal and lock moves to LINKED and its override becomes 3. A lane with loss of signal but with lock stays in SYNC and starts no recovery read.
- R4: In LINKED, a lane without lock moves to CHECK and its `lane_down` bit is 1 after that tick. All `lane_down` bits are cleared when the next accepted tick starts.
- R5: In CHECK, a lane with lock returns to LINKED. A lane without lock runs the recovery check and goes to SYNC. A lane in SYNC without lock runs the recovery check and stays in SYNC.
- R6: The recovery check raises `tb_req` with `tb_sel` = lane + 1 and `tb_ofs` = 5. It holds the request until `tb_ack` and takes the returned 12-bit `tb_data` shifted right by 2 as the loop-filter value.
- R7: If the loop-filter value is below 400 or above 700, the lane's override is 2 for exactly `HOLD_CYC` clock cycles and then 0. For values from 400 to 700 inclusive, the override is left unchanged.
- R8: For a lane whose error count is nonzero on a tick, `err_we` is high for two consecutive cycles carrying that lane's index: first with `err_val` = 0x19, then with 0x00. A lane with a zero count gets no write.
- R9: At the end of each tick `link_up` is 1 exactly when every lane is in LINKED.
- R10: If `link_up` has not been 1 at the end of any tick by the end of the `MAX_TICKS`-th tick after reset (default 2), `timeout` becomes 1 and stays 1 until reset.
- R11: `busy` is 1 while a tick is being processed. A tick that arrives while `busy` is 1 is ignored. Lanes are serviced in increasing index order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Periodic evaluation request |
| busy | output | 1 | A tick is being processed |
| lane_los | input | 2 | Per-lane loss-of-signal |
| lane_stat | input | 64 | Per-lane receive status words (bit 30 lock, 23:16 error count) |
| tb_req | output | 1 | Test-bus read request |
| tb_sel | output | 2 | Test-bus lane select (lane + 1) |
| tb_ofs | output | 4 | Test-bus register offset |
| tb_ack | input | 1 | Test-bus read acknowledge |
| tb_data | input | 12 | Test-bus read data |
| sd_ovr | output | 4 | Per-lane signal-detect override field |
| err_we | output | 1 | Error-counter control write strobe |
| err_lane | output | 1 | Lane addressed by the write |
| err_val | output | 8 | Byte written to the counter control |
| lane_state | output | 4 | Per-lane link state |
| lane_down | output | 2 | Per-lane link-lost flag for the last tick |
| link_up | output | 1 | All lanes linked |
| timeout | output | 1 | Link-up not reached in time |

## Verification
Random ticks mix loss of signal, the lock bit and error counts of zero, 0xFF and other values. The mix separates a true lock from one cancelled by a saturated counter, and ticks that need a counter clear from ticks that do not. Loop-filter readings sit on both edges of the window (399, 400, 700, 701) and at random points. Test-bus acknowledge latency varies, which shows that the reset pulse fires only off-centre and that the request is held. Directed sequences cover the timeout after two failing ticks, the timeout staying quiet once the link came up, and a second tick sent while busy, which must leave the lanes as one tick left them.

// File: rtl/lane_link_mon_pkg.sv
// Shared types and constants for the lane link supervisor.
// Assumes a 32-bit status word per lane with lock and error-count fields.
package lane_link_mon_pkg;

    typedef enum logic [1:0] {
        LS_SYNC   = 2'd0,
        LS_LINKED = 2'd1,
        LS_CHECK  = 2'd2,
        LS_SPARE  = 2'd3
    } lstate_t;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_EVAL,
        SQ_RDREQ,
        SQ_HOLD,
        SQ_CLR_SET,
        SQ_CLR_REL,
        SQ_NEXT,
        SQ_FIN
    } seq_t;

    localparam int STAT_W       = 32;
    localparam int STAT_LOCK    = 30;
    localparam int STAT_ERR_LSB = 16;
    localparam int ERR_W        = 8;

    localparam logic [1:0] SD_RELEASE = 2'd0;
    localparam logic [1:0] SD_RESET   = 2'd2;
    localparam logic [1:0] SD_FORCE   = 2'd3;

    localparam logic [ERR_W-1:0] CLR_ARM  = 8'h19;
    localparam logic [ERR_W-1:0] CLR_DONE = 8'h00;
    localparam logic [ERR_W-1:0] ERR_SAT  = 8'hFF;

endpackage

// File: rtl/lane_link_decide.sv
// Combinational per-lane decision: given the current link state, the
// loss-of-signal bit and the status word, yields the next state and the
// side actions for this tick. Assumes inputs are stable while evaluated.
module lane_link_decide
    import lane_link_mon_pkg::*;
(
    input  lstate_t           cur,
    input  logic              los,
    input  logic [STAT_W-1:0] stat,
    output lstate_t           nxt,
    output logic              go_force,
    output logic              mark_down,
    output logic              want_rec,
    output logic              err_nz
);

    logic [ERR_W-1:0] err_cnt;
    logic             locked;

    assign err_cnt = stat[STAT_ERR_LSB +: ERR_W];
    // Saturated error count overrides the lock flag
    assign locked  = stat[STAT_LOCK] && (err_cnt != ERR_SAT);
    assign err_nz  = (err_cnt != '0);

    // Next-state and action selection
    always_comb begin
        nxt       = cur;
        go_force  = 1'b0;
        mark_down = 1'b0;
        want_rec  = 1'b0;
        unique case (cur)
            LS_SYNC: begin
                if (!los && locked) begin
                    nxt      = LS_LINKED;
                    go_force = 1'b1;
                end else if (!locked) begin
                    want_rec = 1'b1;
                end
            end
            LS_LINKED: begin
                if (!locked) begin
                    nxt       = LS_CHECK;
                    mark_down = 1'b1;
                end
            end
            LS_CHECK: begin
                if (locked) begin
                    nxt = LS_LINKED;
                end else begin
                    want_rec = 1'b1;
                    nxt      = LS_SYNC;
                end
            end
            default: nxt = LS_SYNC;
        endcase
    end

endmodule

// File: rtl/lpf_window.sv
// Combinational window test on a test-bus reading: drops the two low
// bits and flags the value when it falls outside [LO, HI].
module lpf_window #(
    parameter int RAW_W = 12,
    parameter int LO    = 400,
    parameter int HI    = 700
) (
    input  logic [RAW_W-1:0] raw,
    output logic             off_centre
);

    localparam int VW = RAW_W - 2;
    localparam logic [VW-1:0] LO_V = VW'(LO);
    localparam logic [VW-1:0] HI_V = VW'(HI);

    logic [VW-1:0] val;

    assign val        = raw[RAW_W-1:2];
    // Outside-window compare
    assign off_centre = (val < LO_V) || (val > HI_V);

endmodule

// File: rtl/hold_timer.sv
// One-shot cycle counter: after start, runs for CYC cycles and flags the
// last one with done. A new start restarts the count.
module hold_timer #(
    parameter int CYC = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);

    localparam int CW = (CYC > 1) ? $clog2(CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYC - 1);

    logic          run_q;
    logic [CW-1:0] cnt_q;

    // Count cycles while running
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (start) begin
            run_q <= 1'b1;
            cnt_q <= '0;
        end else if (run_q) begin
            if (cnt_q == LAST) run_q <= 1'b0;
            else               cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = run_q && (cnt_q == LAST);

endmodule

// File: rtl/lane_link_mon.sv
// Lane link supervisor top. On each accepted tick, services the lanes in
// index order through one shared decision path: updates the lane state,
// optionally reads the loop filter and pulses a clock-recovery reset,
// clears a nonzero error counter, then updates link-up and timeout.
// Assumes lane inputs hold steady for the duration of a tick.
module lane_link_mon
    import lane_link_mon_pkg::*;
#(
    parameter int NUM_LANES = 2,
    parameter int TB_W      = 12,
    parameter int WIN_LO    = 400,
    parameter int WIN_HI    = 700,
    parameter int HOLD_CYC  = 50,
    parameter int MAX_TICKS = 2,
    parameter int LPF_OFS   = 5
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           tick,
    output logic                           busy,
    input  logic [NUM_LANES-1:0]           lane_los,
    input  logic [NUM_LANES*STAT_W-1:0]    lane_stat,
    output logic                           tb_req,
    output logic [$clog2(NUM_LANES+1)-1:0] tb_sel,
    output logic [3:0]                     tb_ofs,
    input  logic                           tb_ack,
    input  logic [TB_W-1:0]                tb_data,
    output logic [2*NUM_LANES-1:0]         sd_ovr,
    output logic                           err_we,
    output logic [((NUM_LANES>1)?$clog2(NUM_LANES):1)-1:0] err_lane,
    output logic [ERR_W-1:0]               err_val,
    output logic [2*NUM_LANES-1:0]         lane_state,
    output logic [NUM_LANES-1:0]           lane_down,
    output logic                           link_up,
    output logic                           timeout
);

    localparam int IDX_W = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1;
    localparam int SEL_W = $clog2(NUM_LANES + 1);
    localparam int TC_W  = $clog2(MAX_TICKS + 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_LANES - 1);
    localparam logic [TC_W-1:0]  TC_MAX   = TC_W'(MAX_TICKS);
    localparam logic [TC_W-1:0]  TC_ARM   = TC_W'(MAX_TICKS - 1);

    seq_t                       seq_q;
    logic [IDX_W-1:0]           idx_q;
    logic [NUM_LANES-1:0][1:0]  st_q;
    logic [NUM_LANES-1:0][1:0]  sd_q;
    logic [NUM_LANES-1:0]       down_q;
    logic                       errnz_q;
    logic                       link_q;
    logic                       ever_q;
    logic                       to_q;
    logic [TC_W-1:0]            tcnt_q;

    lstate_t           d_nxt;
    logic              d_force, d_down, d_rec, d_errnz;
    logic              off_c, tmr_start, tmr_done;
    logic [NUM_LANES-1:0] lane_ok;

    lane_link_decide u_decide (
        .cur       (lstate_t'(st_q[idx_q])),
        .los       (lane_los[idx_q]),
        .stat      (lane_stat[idx_q*STAT_W +: STAT_W]),
        .nxt       (d_nxt),
        .go_force  (d_force),
        .mark_down (d_down),
        .want_rec  (d_rec),
        .err_nz    (d_errnz)
    );

    lpf_window #(.RAW_W(TB_W), .LO(WIN_LO), .HI(WIN_HI)) u_window (
        .raw        (tb_data),
        .off_centre (off_c)
    );

    assign tmr_start = (seq_q == SQ_RDREQ) && tb_ack && off_c;

    hold_timer #(.CYC(HOLD_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .done  (tmr_done)
    );

    // Per-lane linked flags for the aggregate
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_ok
        assign lane_ok[g] = (st_q[g] == LS_LINKED);
    end

    // Tick sequencer, lane state and supervisor
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q   <= SQ_IDLE;
            idx_q   <= '0;
            st_q    <= '0;
            sd_q    <= '0;
            down_q  <= '0;
            errnz_q <= 1'b0;
            link_q  <= 1'b0;
            ever_q  <= 1'b0;
            to_q    <= 1'b0;
            tcnt_q  <= '0;
        end else begin
            unique case (seq_q)
                SQ_IDLE: begin
                    if (tick) begin
                        down_q <= '0;
                        idx_q  <= '0;
                        seq_q  <= SQ_EVAL;
                    end
                end
                SQ_EVAL: begin
                    st_q[idx_q] <= d_nxt;
                    if (d_force) sd_q[idx_q] <= SD_FORCE;
                    if (d_down)  down_q[idx_q] <= 1'b1;
                    errnz_q <= d_errnz;
                    if (d_rec)        seq_q <= SQ_RDREQ;
                    else if (d_errnz) seq_q <= SQ_CLR_SET;
                    else              seq_q <= SQ_NEXT;
                end
                SQ_RDREQ: begin
                    if (tb_ack) begin
                        if (off_c) begin
                            sd_q[idx_q] <= SD_RESET;
                            seq_q       <= SQ_HOLD;
                        end else begin
                            seq_q <= errnz_q ? SQ_CLR_SET : SQ_NEXT;
                        end
                    end
                end
                SQ_HOLD: begin
                    if (tmr_done) begin
                        sd_q[idx_q] <= SD_RELEASE;
                        seq_q       <= errnz_q ? SQ_CLR_SET : SQ_NEXT;
                    end
                end
                SQ_CLR_SET: seq_q <= SQ_CLR_REL;
                SQ_CLR_REL: seq_q <= SQ_NEXT;
                SQ_NEXT: begin
                    if (idx_q == LAST_IDX) begin
                        seq_q <= SQ_FIN;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                        seq_q <= SQ_EVAL;
                    end
                end
                SQ_FIN: begin
                    link_q <= &lane_ok;
                    if (&lane_ok) ever_q <= 1'b1;
                    if (tcnt_q != TC_MAX) tcnt_q <= tcnt_q + 1'b1;
                    if (!(&lane_ok) && !ever_q && (tcnt_q >= TC_ARM)) to_q <= 1'b1;
                    seq_q <= SQ_IDLE;
                end
                default: seq_q <= SQ_IDLE;
            endcase
        end
    end

    assign busy       = (seq_q != SQ_IDLE);
    assign tb_req     = (seq_q == SQ_RDREQ);
    assign tb_sel     = SEL_W'(idx_q) + 1'b1;
    assign tb_ofs     = 4'(LPF_OFS);
    assign err_we     = (seq_q == SQ_CLR_SET) || (seq_q == SQ_CLR_REL);
    assign err_val    = (seq_q == SQ_CLR_SET) ? CLR_ARM : CLR_DONE;
    assign err_lane   = idx_q;
    assign sd_ovr     = sd_q;
    assign lane_state = st_q;
    assign lane_down  = down_q;
    assign link_up    = link_q;
    assign timeout    = to_q;

endmodule

// File: rtl/lane_link_mon_chk.sv
// Property checker for lane_link_mon, attached by bind below.
module lane_link_mon_chk #(
    parameter int NUM_LANES = 2
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           busy,
    input logic                           tb_req,
    input logic                           tb_ack,
    input logic [$clog2(NUM_LANES+1)-1:0] tb_sel,
    input logic [3:0]                     tb_ofs,
    input logic                           err_we,
    input logic [((NUM_LANES>1)?$clog2(NUM_LANES):1)-1:0] err_lane,
    input logic [7:0]                     err_val,
    input logic [2*NUM_LANES-1:0]         lane_state,
    input logic [NUM_LANES-1:0]           lane_down,
    input logic                           link_up,
    input logic                           timeout
);

    localparam int SEL_W = $clog2(NUM_LANES + 1);

    logic [NUM_LANES-1:0] all_lk;
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lk
        assign all_lk[g] = (lane_state[2*g +: 2] == 2'd1);

        AST_DOWN_FROM_LINKED: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(lane_down[g]) |-> ($past(lane_state[2*g +: 2]) == 2'd1)); // R4
    end

    AST_LINK_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && link_up) |-> (&all_lk)); // R9

    AST_CLR_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (err_we && err_val == 8'h19) |=> (err_we && err_val == 8'h00 && err_lane == $past(err_lane))); // R8

    AST_RD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        tb_req |-> (tb_ofs == 4'd5 && tb_sel >= SEL_W'(1) && tb_sel <= SEL_W'(NUM_LANES))); // R6

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tb_req && !tb_ack) |=> tb_req); // R6

    AST_TO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> timeout); // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!tb_req && !err_we)); // R11

endmodule

bind lane_link_mon lane_link_mon_chk #(.NUM_LANES(NUM_LANES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .tb_req     (tb_req),
    .tb_ack     (tb_ack),
    .tb_sel     (tb_sel),
    .tb_ofs     (tb_ofs),
    .err_we     (err_we),
    .err_lane   (err_lane),
    .err_val    (err_val),
    .lane_state (lane_state),
    .lane_down  (lane_down),
    .link_up    (link_up),
    .timeout    (timeout)
);

// File: tb/lane_link_mon_tb_top.sv
module lane_link_mon_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NL   = 2;
    localparam int HOLD = 12;
    localparam int MAXT = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        busy;
    logic [1:0]  lane_los = '0;
    logic [63:0] lane_stat = '0;
    logic        tb_req;
    logic [1:0]  tb_sel;
    logic [3:0]  tb_ofs;
    logic        tb_ack = 1'b0;
    logic [11:0] tb_data = '0;
    logic [3:0]  sd_ovr;
    logic        err_we;
    logic [0:0]  err_lane;
    logic [7:0]  err_val;
    logic [3:0]  lane_state;
    logic [1:0]  lane_down;
    logic        link_up;
    logic        timeout;

    always #(CLK_PERIOD/2) clk = ~clk;

    lane_link_mon #(.NUM_LANES(NL), .HOLD_CYC(HOLD), .MAX_TICKS(MAXT)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .busy(busy),
        .lane_los(lane_los), .lane_stat(lane_stat),
        .tb_req(tb_req), .tb_sel(tb_sel), .tb_ofs(tb_ofs),
        .tb_ack(tb_ack), .tb_data(tb_data),
        .sd_ovr(sd_ovr), .err_we(err_we), .err_lane(err_lane), .err_val(err_val),
        .lane_state(lane_state), .lane_down(lane_down),
        .link_up(link_up), .timeout(timeout)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // test-bus stimulus and monitor counters
    logic [11:0] lpf_word [NL];
    int rd_wait = 0;
    int wcnt = 0;
    int n_rd [NL];
    int n_pulse [NL];
    int n_arm [NL];
    int n_rel [NL];
    int last_lane = 0;

    // reference model
    int m_st [NL];
    int m_sd [NL];
    int e_down [NL];
    int e_rd [NL];
    int e_pulse [NL];
    int e_clr [NL];
    int m_ticks = 0;
    int m_ever = 0;
    int m_to = 0;
    int e_link = 0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // test-bus responder and observation monitor, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (tb_req && !tb_ack) begin
                if (wcnt == 0) begin
                    chk(tb_ofs == 4'd5, "R6", "tb_ofs", int'(tb_ofs), 5);
                    if (tb_sel >= 2'd1 && tb_sel <= 2'd2) n_rd[tb_sel-1]++;
                    else chk(1'b0, "R6", "tb_sel range", int'(tb_sel), 1);
                end
                if (wcnt >= rd_wait) begin
                    tb_ack  <= 1'b1;
                    tb_data <= lpf_word[(tb_sel == 2'd2) ? 1 : 0];
                    wcnt    <= 0;
                end else begin
                    wcnt <= wcnt + 1;
                end
            end else begin
                tb_ack <= 1'b0;
            end
            for (int l = 0; l < NL; l++)
                if (sd_ovr[2*l +: 2] == 2'd2) n_pulse[l]++;
            if (err_we && err_val == 8'h19) begin
                n_arm[err_lane]++;
                if (int'(err_lane) < last_lane)
                    chk(1'b0, "R11", "lane order", int'(err_lane), last_lane);
                last_lane = int'(err_lane);
            end
            if (err_we && err_val == 8'h00) n_rel[err_lane]++;
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic model_reset();
        for (int l = 0; l < NL; l++) begin
            m_st[l] = 0; m_sd[l] = 0;
        end
        m_ticks = 0; m_ever = 0; m_to = 0; e_link = 0;
    endtask

    task automatic model_tick();
        for (int l = 0; l < NL; l++) begin
            logic [31:0] s;
            logic lk;
            logic rec;
            int v;
            s   = lane_stat[32*l +: 32];
            lk  = s[30] && (s[23:16] != 8'hFF);      // R2
            rec = 1'b0;
            e_down[l] = 0;
            case (m_st[l])
                0: if (!lane_los[l] && lk) begin m_st[l] = 1; m_sd[l] = 3; end   // R3
                   else if (!lk) rec = 1'b1;
                1: if (!lk) begin e_down[l] = 1; m_st[l] = 2; end                // R4
                default: if (lk) m_st[l] = 1; else begin rec = 1'b1; m_st[l] = 0; end // R5
            endcase
            v = int'(lpf_word[l] >> 2);
            e_rd[l] = rec ? 1 : 0;
            e_pulse[l] = (rec && (v < 400 || v > 700)) ? HOLD : 0;               // R7
            if (e_pulse[l] != 0) m_sd[l] = 0;
            e_clr[l] = (s[23:16] != 8'h00) ? 1 : 0;                              // R8
        end
        e_link = (m_st[0] == 1 && m_st[1] == 1) ? 1 : 0;                         // R9
        m_ticks++;
        if (e_link != 0) m_ever = 1;
        if (e_link == 0 && m_ever == 0 && m_ticks >= MAXT) m_to = 1;            // R10
    endtask

    task automatic clear_mon();
        for (int l = 0; l < NL; l++) begin
            n_rd[l] = 0; n_pulse[l] = 0; n_arm[l] = 0; n_rel[l] = 0;
        end
        last_lane = 0;
    endtask

    task automatic compare_all(input string tag);
        for (int l = 0; l < NL; l++) begin
            chk(int'(lane_state[2*l +: 2]) == m_st[l], "R3/R4/R5", {tag, " state"}, int'(lane_state[2*l +: 2]), m_st[l]);
            chk(int'(sd_ovr[2*l +: 2]) == m_sd[l], "R3 R7", {tag, " sd_ovr"}, int'(sd_ovr[2*l +: 2]), m_sd[l]);
            chk(int'(lane_down[l]) == e_down[l], "R4", {tag, " lane_down"}, int'(lane_down[l]), e_down[l]);
            chk(n_rd[l] == e_rd[l], "R6", {tag, " reads"}, n_rd[l], e_rd[l]);
            chk(n_pulse[l] == e_pulse[l], "R7", {tag, " pulse cycles"}, n_pulse[l], e_pulse[l]);
            chk(n_arm[l] == e_clr[l] && n_rel[l] == e_clr[l], "R8", {tag, " clear writes"}, n_arm[l] + n_rel[l], 2 * e_clr[l]);
        end
        chk(int'(link_up) == e_link, "R9", {tag, " link_up"}, int'(link_up), e_link);
        chk(int'(timeout) == m_to, "R10", {tag, " timeout"}, int'(timeout), m_to);
        chk(busy == 1'b0, "R11", {tag, " busy"}, int'(busy), 0);
    endtask

    task automatic do_tick(input string tag);
        clear_mon();
        model_tick();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        while (busy) @(negedge clk);
        compare_all(tag);
    endtask

    function automatic logic [31:0] mk_stat(input logic lk, input logic [7:0] err);
        logic [31:0] s;
        s = '0;
        s[30] = lk;
        s[23:16] = err;
        return s;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        @(negedge clk);
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20240611);
        lpf_word[0] = 12'd0;
        lpf_word[1] = 12'd0;

        do_reset();
        // R1 reset state
        chk(lane_state == 4'd0, "R1", "reset state", int'(lane_state), 0);
        chk(sd_ovr == 4'd0, "R1", "reset sd_ovr", int'(sd_ovr), 0);
        chk(lane_down == 2'd0 && !link_up && !timeout && !busy, "R1", "reset flags",
            int'({lane_down, link_up, timeout, busy}), 0);

        // R10: two failing ticks raise timeout; off-centre reads pulse (R7)
        lane_stat = {mk_stat(1'b0, 8'h00), mk_stat(1'b0, 8'h00)};
        lpf_word[0] = 12'(399 << 2);
        lpf_word[1] = 12'(701 << 2);
        do_tick("to1");
        lpf_word[0] = 12'(400 << 2);
        lpf_word[1] = 12'((700 << 2) | 3);
        do_tick("to2");
        // R3: loss with lock stays in SYNC
        lane_los  = 2'b11;
        lane_stat = {mk_stat(1'b1, 8'h00), mk_stat(1'b1, 8'h00)};
        do_tick("los");
        // R2: saturated count defeats lock
        lane_los  = 2'b00;
        lane_stat = {mk_stat(1'b1, 8'h00), mk_stat(1'b1, 8'hFF)};
        do_tick("sat");

        // R10 negative: link up on first tick, timeout stays low
        do_reset();
        lane_stat = {mk_stat(1'b1, 8'h03), mk_stat(1'b1, 8'h00)};
        do_tick("up1");
        lane_stat = {mk_stat(1'b1, 8'h00), mk_stat(1'b1, 8'h00)};
        do_tick("up2");
        do_tick("up3");

        // R11: second tick while busy is ignored
        lane_stat = {mk_stat(1'b1, 8'h00), mk_stat(1'b0, 8'h05)};
        clear_mon();
        model_tick();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        while (busy) @(negedge clk);
        repeat (3) begin
            @(negedge clk);
            chk(busy == 1'b0, "R11", "ignored tick busy", int'(busy), 0);
        end
        compare_all("ign");

        // random phase
        for (int n = 0; n < 60; n++) begin
            logic [7:0] e;
            int pick;
            for (int l = 0; l < NL; l++) begin
                pick = int'($urandom_range(0, 9));
                e = (pick < 5) ? 8'h00 : (pick < 7) ? 8'hFF : 8'($urandom_range(1, 254));
                lane_stat[32*l +: 32] = mk_stat(($urandom_range(0, 3) != 0), e);
                lane_los[l] = ($urandom_range(0, 4) == 0);
                pick = int'($urandom_range(0, 5));
                case (pick)
                    0: lpf_word[l] = 12'(399 << 2);
                    1: lpf_word[l] = 12'(400 << 2);
                    2: lpf_word[l] = 12'((700 << 2) | 3);
                    3: lpf_word[l] = 12'(701 << 2);
                    default: lpf_word[l] = 12'($urandom_range(0, 4095));
                endcase
            end
            rd_wait = int'($urandom_range(0, 3));
            do_tick("rnd");
            if (n == 30) begin
                do_reset();
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule